// File: doc/BRIEF.md
# Registered Integer ALU with Branch Condition

This block is the integer execute unit of a 32-bit RISC-style core. Each cycle it takes two operands, a 5-bit operation select and a 5-bit shift count. It produces a 32-bit result, a 64-bit high/low pair for multiply and divide, and a single condition bit that the branch logic uses.

All the function is computed combinationally. A single output register stage then holds the outputs, so every result appears one clock after its inputs were presented. The operation set includes:

- wrapping add and subtract
- bitwise logic
- shifts, taking the count either from the instruction field or from an operand
- signed and unsigned set-less-than
- a move path
- signed and unsigned multiply and divide
- six branch comparisons

A load-upper-immediate is issued as a left shift by 16 with the field count.

Top module: `int_alu`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs become zero at that edge. Outside reset, the outputs at the edge after a set of inputs is sampled reflect those inputs, which gives one cycle of latency.
- R2: Op 0 gives a+b and op 1 gives a-b, both modulo 2^32 with no overflow indication.
- R3: Op 4 gives a AND b, op 5 gives a OR b, and op 6 gives a XOR b.
- R4: Ops 7, 9 and 11 shift operand b by `shamt_i`. Op 7 is a logical left shift, op 9 a logical right shift and op 11 an arithmetic right shift that copies b[31]. Op 7 with a count of 16 places b[15:0] in the upper half.
- R5: Ops 8, 10 and 12 behave like ops 7, 9 and 11 but take the count from a[4:0]. a[31:5] and `shamt_i` have no effect.
- R6: The compare ops set `cond_o` and leave `result_o` at zero:
  - op 13: a==b
  - op 18: a!=b
  - op 14: a<0 (signed)
  - op 15: a<=0 (signed)
  - op 16: a>0 (signed)
  - op 17: a>=0 (signed)
- R7: For every op other than 13 to 18, `cond_o` is 0.
- R8: Op 20 returns 1 when a<b as signed values and 0 otherwise. Op 21 does the same for unsigned values.
- R9: Op 2 (signed) and op 22 (unsigned) place the 64-bit product on {`hi_o`,`lo_o`}, and `result_o` equals `lo_o`.
- R10: Op 3 (signed) and op 23 (unsigned) put the quotient on `lo_o` and `result_o`, and the remainder on `hi_o`. Signed division truncates toward zero and the remainder takes the sign of a. The case 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R11: Division by zero, signed or unsigned, gives zero on `result_o`, `hi_o` and `lo_o`.
- R12: Op 19 returns a unchanged on `result_o`.
- R13: Ops 24 to 31 give zero on every output. `hi_o` and `lo_o` are zero for every op other than 2, 3, 22 and 23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation select |
| a_i | input | 32 | First operand; also the variable shift count and the move source |
| b_i | input | 32 | Second operand; the data that shifts act on |
| shamt_i | input | 5 | Shift count from the instruction field |
| result_o | output | 32 | Main result |
| hi_o | output | 32 | Product upper half or division remainder |
| lo_o | output | 32 | Product lower half or quotient |
| cond_o | output | 1 | Branch condition |

## Verification
Every output of this block is due exactly one rising edge after the inputs that produce it are sampled, with no path that is faster or slower.

The driver applies one operation on each falling edge and queues the values it expects. The monitor pops the queue shortly after the next rising edge, so each comparison falls inside the window where that operation's registered outputs are held.

Reset is checked at a falling edge while reset is held, with non-zero inputs applied.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned XLEN = 32;
    localparam int unsigned SHW  = $clog2(XLEN);

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_SUB  = 5'd1,
        OP_MUL  = 5'd2,
        OP_DIV  = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_SLL  = 5'd7,
        OP_SLLV = 5'd8,
        OP_SRL  = 5'd9,
        OP_SRLV = 5'd10,
        OP_SRA  = 5'd11,
        OP_SRAV = 5'd12,
        OP_EQ   = 5'd13,
        OP_LTZ  = 5'd14,
        OP_LEZ  = 5'd15,
        OP_GTZ  = 5'd16,
        OP_GEZ  = 5'd17,
        OP_NE   = 5'd18,
        OP_PASS = 5'd19,
        OP_SLT  = 5'd20,
        OP_SLTU = 5'd21,
        OP_MULU = 5'd22,
        OP_DIVU = 5'd23
    } alu_op_e;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic [XLEN-1:0] hi;
        logic [XLEN-1:0] lo;
        logic            cond;
    } alu_out_t;

    function automatic logic is_compare(input logic [4:0] op);
        return (op >= 5'd13) && (op <= 5'd18);
    endfunction

    function automatic logic is_muldiv(input logic [4:0] op);
        return (op == OP_MUL) || (op == OP_MULU) || (op == OP_DIV) || (op == OP_DIVU);
    endfunction

    function automatic logic is_var_shift(input alu_op_e op);
        return (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV);
    endfunction

endpackage

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
    import alu_pkg::*;
#(
    parameter int unsigned W   = 32,
    parameter int unsigned SW  = $clog2(W)
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   data,
    input  logic [SW-1:0]  field_amt,
    input  logic [SW-1:0]  reg_amt,
    output logic [W-1:0]   y
);
    logic [SW-1:0] amt;

    assign amt = is_var_shift(op) ? reg_amt : field_amt;

    always_comb begin
        case (op)
            OP_SLL, OP_SLLV: y = data << amt;
            OP_SRL, OP_SRLV: y = data >> amt;
            OP_SRA, OP_SRAV: y = W'($signed(data) >>> amt);
            default:         y = '0;
        endcase
    end
endmodule

// File: rtl/alu_compare_unit.sv
module alu_compare_unit
    import alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         cond
);
    logic a_neg;
    logic a_zero;

    assign a_neg  = a[W-1];
    assign a_zero = (a == '0);

    always_comb begin
        case (op)
            OP_EQ:   cond = (a == b);
            OP_NE:   cond = (a != b);
            OP_LTZ:  cond = a_neg;
            OP_LEZ:  cond = a_neg | a_zero;
            OP_GTZ:  cond = !a_neg && !a_zero;
            OP_GEZ:  cond = !a_neg;
            default: cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_muldiv_unit.sv
module alu_muldiv_unit
    import alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    logic [2*W-1:0] prod_s;
    logic [2*W-1:0] prod_u;
    logic [W-1:0]   quo_s, rem_s, quo_u, rem_u;
    logic           div_zero;
    logic           div_ovf;

    assign prod_s   = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
    assign prod_u   = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    assign div_zero = (b == '0);
    assign div_ovf  = (a == MIN_NEG) && (b == '1);

    always_comb begin
        if (div_zero) begin
            quo_s = '0;
            rem_s = '0;
            quo_u = '0;
            rem_u = '0;
        end else begin
            quo_u = a / b;
            rem_u = a % b;
            if (div_ovf) begin
                quo_s = MIN_NEG;
                rem_s = '0;
            end else begin
                quo_s = W'($signed(a) / $signed(b));
                rem_s = W'($signed(a) % $signed(b));
            end
        end
    end

    always_comb begin
        case (op)
            OP_MUL:  {hi, lo} = prod_s;
            OP_MULU: {hi, lo} = prod_u;
            OP_DIV:  {hi, lo} = {rem_s, quo_s};
            OP_DIVU: {hi, lo} = {rem_u, quo_u};
            default: {hi, lo} = '0;
        endcase
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import alu_pkg::*;
#(
    parameter int unsigned W  = XLEN,
    localparam int unsigned SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [4:0]    op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic [SW-1:0] shamt_i,
    output logic [W-1:0]  result_o,
    output logic [W-1:0]  hi_o,
    output logic [W-1:0]  lo_o,
    output logic          cond_o
);
    typedef struct packed {
        logic [W-1:0] result;
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        logic         cond;
    } out_t;

    alu_op_e      op;
    logic [W-1:0] shift_y;
    logic [W-1:0] md_hi, md_lo;
    logic         cmp_cond;
    out_t         nxt, q;

    assign op = alu_op_e'(op_i);

    alu_shift_unit #(.W(W), .SW(SW)) u_shift (
        .op        (op),
        .data      (b_i),
        .field_amt (shamt_i),
        .reg_amt   (a_i[SW-1:0]),
        .y         (shift_y)
    );

    alu_compare_unit #(.W(W)) u_cmp (
        .op   (op),
        .a    (a_i),
        .b    (b_i),
        .cond (cmp_cond)
    );

    alu_muldiv_unit #(.W(W)) u_md (
        .op (op),
        .a  (a_i),
        .b  (b_i),
        .hi (md_hi),
        .lo (md_lo)
    );

    always_comb begin
        nxt = '0;
        case (op)
            OP_ADD:  nxt.result = a_i + b_i;
            OP_SUB:  nxt.result = a_i - b_i;
            OP_AND:  nxt.result = a_i & b_i;
            OP_OR:   nxt.result = a_i | b_i;
            OP_XOR:  nxt.result = a_i ^ b_i;
            OP_SLL, OP_SLLV, OP_SRL, OP_SRLV, OP_SRA, OP_SRAV:
                     nxt.result = shift_y;
            OP_SLT:  nxt.result = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
            OP_SLTU: nxt.result = {{(W-1){1'b0}}, a_i < b_i};
            OP_PASS: nxt.result = a_i;
            OP_MUL, OP_MULU, OP_DIV, OP_DIVU: begin
                nxt.hi     = md_hi;
                nxt.lo     = md_lo;
                nxt.result = md_lo;
            end
            OP_EQ, OP_NE, OP_LTZ, OP_LEZ, OP_GTZ, OP_GEZ:
                     nxt.cond = cmp_cond;
            default: nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign result_o = q.result;
    assign hi_o     = q.hi;
    assign lo_o     = q.lo;
    assign cond_o   = q.cond;

    assert_add_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ADD) |=> (result_o - $past(b_i) == $past(a_i)));

    assert_sub_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SUB) |=> (result_o + $past(b_i) == $past(a_i)));

    assert_cond_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !is_compare(op_i) |=> !cond_o);

    assert_slt_bool_R8: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SLT || op_i == OP_SLTU) |=> (result_o[W-1:1] == '0));

    assert_divu_identity_R10: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_DIVU && b_i != '0) |=>
        ((lo_o * $past(b_i) + hi_o == $past(a_i)) && (hi_o < $past(b_i))));

    assert_div_zero_R11: assert property (@(posedge clk) disable iff (rst)
        ((op_i == OP_DIV || op_i == OP_DIVU) && b_i == '0) |=>
        (hi_o == '0 && lo_o == '0 && result_o == '0));

    assert_pass_R12: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_PASS) |=> (result_o == $past(a_i)));

    assert_spare_ops_R13: assert property (@(posedge clk) disable iff (rst)
        (op_i > 5'd23) |=> (result_o == '0 && hi_o == '0 && lo_o == '0 && !cond_o));

    assert_hilo_idle_R13: assert property (@(posedge clk) disable iff (rst)
        !is_muldiv(op_i) |=> (hi_o == '0 && lo_o == '0));
endmodule

// File: tb/int_alu_tb.sv
module int_alu_tb;
    import alu_pkg::*;

    typedef struct {
        logic [31:0] res;
        logic [31:0] hi;
        logic [31:0] lo;
        logic        cond;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op_i = 5'd0;
    logic [31:0] a_i = 32'd0;
    logic [31:0] b_i = 32'd0;
    logic [4:0]  shamt_i = 5'd0;
    logic [31:0] result_o, hi_o, lo_o;
    logic        cond_o;

    int checks = 0;
    int errors = 0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    int_alu u_dut (
        .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .shamt_i(shamt_i), .result_o(result_o), .hi_o(hi_o),
        .lo_o(lo_o), .cond_o(cond_o)
    );

    function automatic exp_t model(input logic [4:0] op, input logic [31:0] a,
                                   input logic [31:0] b, input logic [4:0] sh);
        exp_t e;
        logic [63:0] p;
        logic [31:0] ma, mb, mq, mr;
        logic [4:0]  n;
        e.res = 0; e.hi = 0; e.lo = 0; e.cond = 0; e.tag = "rand";
        n = (op == 8 || op == 10 || op == 12) ? a[4:0] : sh;
        case (op)
            0: e.res = a + b;
            1: e.res = a - b;
            4: e.res = a & b;
            5: e.res = a | b;
            6: e.res = a ^ b;
            7, 8: e.res = b << n;
            9, 10: e.res = b >> n;
            11, 12: begin
                e.res = b >> n;
                for (int i = 0; i < 32; i++) if (b[31] && i >= 32 - n) e.res[i] = 1'b1;
            end
            13: e.cond = (a == b);
            18: e.cond = (a != b);
            14: e.cond = a[31];
            15: e.cond = a[31] || a == 0;
            16: e.cond = !a[31] && a != 0;
            17: e.cond = !a[31];
            19: e.res = a;
            20: e.res = (a[31] != b[31]) ? {31'd0, a[31]} : {31'd0, a < b};
            21: e.res = {31'd0, a < b};
            2, 22: begin
                ma = (op == 2 && a[31]) ? -a : a;
                mb = (op == 2 && b[31]) ? -b : b;
                p = {32'd0, ma} * {32'd0, mb};
                if (op == 2 && (a[31] ^ b[31])) p = -p;
                {e.hi, e.lo} = p; e.res = e.lo;
            end
            3, 23: begin
                if (b != 0) begin
                    ma = (op == 3 && a[31]) ? -a : a;
                    mb = (op == 3 && b[31]) ? -b : b;
                    mq = ma / mb; mr = ma % mb;
                    if (op == 3 && (a[31] ^ b[31])) mq = -mq;
                    if (op == 3 && a[31]) mr = -mr;
                    e.lo = mq; e.hi = mr; e.res = mq;
                end
            end
            default: ;
        endcase
        return e;
    endfunction

    task automatic send(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [4:0] sh, input logic [31:0] er, input logic [31:0] eh,
                        input logic [31:0] el, input logic ec, input string tag);
        exp_t e;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; shamt_i = sh;
        e.res = er; e.hi = eh; e.lo = el; e.cond = ec; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic send_model(input logic [4:0] op, input logic [31:0] a,
                              input logic [31:0] b, input logic [4:0] sh, input string tag);
        exp_t e;
        e = model(op, a, b, sh);
        send(op, a, b, sh, e.res, e.hi, e.lo, e.cond, tag);
    endtask

    always @(posedge clk) begin
        #2;
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (result_o !== e.res || hi_o !== e.hi || lo_o !== e.lo || cond_o !== e.cond) begin
                errors++;
                $display("FAIL %s: got res=%h hi=%h lo=%h cond=%b exp res=%h hi=%h lo=%h cond=%b",
                         e.tag, result_o, hi_o, lo_o, cond_o, e.res, e.hi, e.lo, e.cond);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        op_i = 5'd0; a_i = 32'd5; b_i = 32'd6;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (result_o !== 0 || hi_o !== 0 || lo_o !== 0 || cond_o !== 0) begin
            errors++;
            $display("FAIL R1 reset: got res=%h hi=%h lo=%h cond=%b exp all zero",
                     result_o, hi_o, lo_o, cond_o);
        end
        rst = 1'b0;

        send(0, 32'hFFFFFFFF, 32'd1, 0, 32'd0, 0, 0, 0, "R2 R7 add wrap");
        send(1, 32'd0, 32'd1, 0, 32'hFFFFFFFF, 0, 0, 0, "R2 sub wrap");
        send(4, 32'hF0F0F0F0, 32'h0FF00FF0, 0, 32'h00F000F0, 0, 0, 0, "R3 and");
        send(5, 32'hF0F0F0F0, 32'h0FF00FF0, 0, 32'hFFF0FFF0, 0, 0, 0, "R3 or");
        send(6, 32'hF0F0F0F0, 32'h0FF00FF0, 0, 32'hFF00FF00, 0, 0, 0, "R3 xor");
        send(7, 32'h0, 32'd1, 5'd31, 32'h80000000, 0, 0, 0, "R4 sll");
        send(7, 32'h0, 32'h00001234, 5'd16, 32'h12340000, 0, 0, 0, "R4 upper imm");
        send(9, 32'h0, 32'h80000000, 5'd4, 32'h08000000, 0, 0, 0, "R4 srl");
        send(11, 32'h0, 32'h80000000, 5'd4, 32'hF8000000, 0, 0, 0, "R4 sra");
        send(8, 32'hFFFFFFE3, 32'd1, 5'd7, 32'd8, 0, 0, 0, "R5 sllv");
        send(10, 32'h00000024, 32'hF0, 5'd9, 32'h0F, 0, 0, 0, "R5 srlv");
        send(12, 32'h0000001F, 32'h80000000, 5'd1, 32'hFFFFFFFF, 0, 0, 0, "R5 srav");
        send(13, 32'd9, 32'd9, 0, 0, 0, 0, 1, "R6 eq");
        send(13, 32'd9, 32'd8, 0, 0, 0, 0, 0, "R6 eq miss");
        send(18, 32'd9, 32'd8, 0, 0, 0, 0, 1, "R6 ne");
        send(14, 32'hFFFFFFFF, 0, 0, 0, 0, 0, 1, "R6 ltz");
        send(14, 32'd0, 0, 0, 0, 0, 0, 0, "R6 ltz zero");
        send(15, 32'd0, 0, 0, 0, 0, 0, 1, "R6 lez zero");
        send(16, 32'd0, 0, 0, 0, 0, 0, 0, "R6 gtz zero");
        send(16, 32'd1, 0, 0, 0, 0, 0, 1, "R6 gtz one");
        send(17, 32'h80000000, 0, 0, 0, 0, 0, 0, "R6 gez min");
        send(17, 32'd0, 0, 0, 0, 0, 0, 1, "R6 gez zero");
        send(20, 32'hFFFFFFFF, 32'd1, 0, 32'd1, 0, 0, 0, "R8 slt");
        send(21, 32'hFFFFFFFF, 32'd1, 0, 32'd0, 0, 0, 0, "R8 sltu");
        send(2, 32'hFFFFFFFF, 32'd2, 0, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'hFFFFFFFE, 0, "R9 mul");
        send(22, 32'hFFFFFFFF, 32'd2, 0, 32'hFFFFFFFE, 32'd1, 32'hFFFFFFFE, 0, "R9 mulu");
        send(3, 32'hFFFFFFF9, 32'd2, 0, 32'hFFFFFFFD, 32'hFFFFFFFF, 32'hFFFFFFFD, 0, "R10 div");
        send(23, 32'd7, 32'd2, 0, 32'd3, 32'd1, 32'd3, 0, "R10 divu");
        send(3, 32'h80000000, 32'hFFFFFFFF, 0, 32'h80000000, 0, 32'h80000000, 0, "R10 div min");
        send(3, 32'd123, 32'd0, 0, 0, 0, 0, 0, "R11 div zero");
        send(23, 32'd123, 32'd0, 0, 0, 0, 0, 0, "R11 divu zero");
        send(19, 32'hDEADBEEF, 32'd5, 0, 32'hDEADBEEF, 0, 0, 0, "R12 pass");
        send(24, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3, 0, 0, 0, 0, "R13 spare 24");
        send(31, 32'h12345678, 32'h9, 5'd3, 0, 0, 0, 0, "R13 spare 31");

        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 240; i++) begin
            logic [31:0] ra, rb;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ra = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rb = (i % 7 == 0) ? (lfsr & 32'hF) : lfsr;
            send_model(5'(i % 24), ra, rb, lfsr[4:0], "R2-R13 sweep");
        end

        repeat (4) @(posedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule